// File: doc/BRIEF.md
# Dual-Rail Spike Latency Encoder

This block turns a short vector of signed fixed-point coefficients into a spike pattern in time. Coefficients are written one at a time through a load port. A start pulse then opens an input window of T+1 timesteps, numbered 0 to T. Each tick moves the window on by one step and produces a bitmask of the channels that spike on that step. The window ends on step T.

Each spike time is relative to the largest magnitude in the vector, e_max. A coefficient whose magnitude equals e_max fires on step 0. Smaller magnitudes fire later, up to step T. Positive values drive channel i. Negative values drive the mirrored channel i+NC, so a strong coefficient of either sign fires early. A component that is small compared with e_max is pruned and fires on neither rail. The pruning threshold is a runtime input. It is given as an unsigned fraction and captured at start.

The block does not compute the coefficients and does not route the spikes.

Top module: `dual_rail_latency_encoder`

## Requirements
- R1: A load_valid pulse while idle writes load_coef (two's complement, CW bits) into coefficient slot load_idx. A load_valid pulse while busy is ignored.
- R2: When start is high while idle, busy goes high. Each later tick while busy produces, one cycle after the tick, a single-cycle spike_valid pulse that carries spike_mask and spike_step for the current step. Steps count 0, 1, ... T. On the step-T pulse, done is high for that one cycle and busy is low from the same cycle. A tick while idle gives no spike_valid.
- R3: e_max is the largest |coefficient| in the vector at start. Every channel whose magnitude equals e_max fires on step 0.
- R4: A positive coefficient in slot i fires on spike_mask bit i at step floor((2·T·(e_max−|e|) + e_max) / (2·e_max)). This is T·(1−|e|/e_max) rounded to the nearest step, with halves rounded up.
- R5: A negative coefficient in slot i fires on spike_mask bit i+NC, at the same step formula as R4. It never fires on bit i.
- R6: A coefficient with |e|·2^FW < thresh·e_max is pruned and gives no spike. thresh is captured at start.
- R7: A zero coefficient never fires. An all-zero vector gives empty masks for the whole window, and done still comes on step T.
- R8: Each channel fires at most once per window.
- R9: A start while busy is ignored, and the window keeps its original step count. A load that arrives in the same cycle as the final tick is also ignored.
- R10: After reset, busy, spike_valid and done are low, and every coefficient slot holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_valid | input | 1 | Write strobe for one coefficient |
| load_idx | input | IW | Coefficient slot to write |
| load_coef | input | CW | Signed coefficient value |
| thresh | input | FW | Pruning fraction, thresh/2^FW, captured at start |
| start | input | 1 | Opens a window when idle |
| tick | input | 1 | Advances the window by one step |
| busy | output | 1 | Window in progress |
| spike_valid | output | 1 | One pulse per processed step |
| spike_mask | output | 2*NC | Channels firing this step, positive rail low half |
| spike_step | output | SW | Step number of the current mask |
| done | output | 1 | Pulses with the step-T mask |

## Verification
Two functions can meet in one clock cycle: the final tick that closes a window, and a load or start that arrives at the same time. The busy state that blocks new loads is still set during that cycle. The bench therefore drives a load together with the step-T tick, and separately a start in the middle of a window. It then judges both cases by running the next window and checking that its spike pattern matches the coefficients that were stored earlier, and that the interrupted window still ends exactly on step T.

// File: rtl/dre_pkg.sv
package dre_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} dre_state_e;
endpackage

// File: rtl/dre_maxmag.sv
module dre_maxmag #(
  parameter int NC = 4,
  parameter int MW = 8
) (
  input  logic [NC*MW-1:0] mags,
  output logic [MW-1:0]    max_o
);
  always_comb begin
    max_o = '0;
    for (int i = 0; i < NC; i++) begin
      if (mags[i*MW +: MW] > max_o) max_o = mags[i*MW +: MW];
    end
  end
endmodule

// File: rtl/dre_chan.sv
module dre_chan #(
  parameter int MW = 8,
  parameter int FW = 8,
  parameter int T  = 60,
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          step_en,
  input  logic [MW-1:0] mag,
  input  logic          neg,
  input  logic [MW-1:0] emax,
  input  logic [FW-1:0] thr,
  input  logic [NW-1:0] acc,
  output logic          fire_pos,
  output logic          fire_neg
);
  localparam int PW = MW + FW;

  logic          fired_q, fired_d;
  logic [NW-1:0] num;
  logic [PW-1:0] lhs, rhs;
  logic          active, hit;

  always_comb begin
    num    = NW'(2 * T) * (NW'(emax) - NW'(mag)) + NW'(emax);
    lhs    = {mag, {FW{1'b0}}};
    rhs    = PW'(thr) * PW'(emax);
    active = (mag != '0) && !(lhs < rhs);
    hit    = step_en && active && !fired_q && (num < acc);
    fire_pos = hit && !neg;
    fire_neg = hit && neg;
    fired_d = fired_q;
    if (arm)      fired_d = 1'b0;
    else if (hit) fired_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fired_q <= 1'b0;
    else        fired_q <= fired_d;
  end
endmodule

// File: rtl/dual_rail_latency_encoder.sv
module dual_rail_latency_encoder #(
  parameter int NC = 4,
  parameter int CW = 8,
  parameter int FW = 8,
  parameter int T  = 60,
  parameter int IW = (NC > 1) ? $clog2(NC) : 1,
  parameter int SW = $clog2(T + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_valid,
  input  logic [IW-1:0]        load_idx,
  input  logic signed [CW-1:0] load_coef,
  input  logic [FW-1:0]        thresh,
  input  logic                 start,
  input  logic                 tick,
  output logic                 busy,
  output logic                 spike_valid,
  output logic [2*NC-1:0]      spike_mask,
  output logic [SW-1:0]        spike_step,
  output logic                 done
);
  import dre_pkg::*;

  localparam int MW = CW;
  localparam int NW = MW + $clog2(2 * T + 4) + 1;

  dre_state_e          st_q, st_d;
  logic [CW-1:0]       coef_q [NC];
  logic [CW-1:0]       coef_d [NC];
  logic [MW-1:0]       emax_q, emax_d, emax_c;
  logic [FW-1:0]       thr_q, thr_d;
  logic [NW-1:0]       acc_q, acc_d;
  logic [SW-1:0]       step_q, step_d;
  logic                sv_q, sv_d, done_q, done_d;
  logic [2*NC-1:0]     mask_q, mask_d, fire;
  logic [SW-1:0]       sstep_q, sstep_d;
  logic [NC*MW-1:0]    mag_flat;
  logic [NC-1:0]       neg_v;
  logic                accept_start, step_en;

  assign accept_start = (st_q == ST_IDLE) && start;
  assign step_en      = (st_q == ST_RUN) && tick;

  for (genvar g = 0; g < NC; g++) begin : g_chan
    always_comb begin
      neg_v[g] = coef_q[g][CW-1];
      mag_flat[g*MW +: MW] = neg_v[g] ? (~coef_q[g] + 1'b1) : coef_q[g];
    end

    dre_chan #(.MW(MW), .FW(FW), .T(T), .NW(NW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (accept_start),
      .step_en  (step_en),
      .mag      (mag_flat[g*MW +: MW]),
      .neg      (neg_v[g]),
      .emax     (emax_q),
      .thr      (thr_q),
      .acc      (acc_q),
      .fire_pos (fire[g]),
      .fire_neg (fire[g+NC])
    );
  end

  dre_maxmag #(.NC(NC), .MW(MW)) u_max (
    .mags  (mag_flat),
    .max_o (emax_c)
  );

  always_comb begin
    st_d    = st_q;
    emax_d  = emax_q;
    thr_d   = thr_q;
    acc_d   = acc_q;
    step_d  = step_q;
    sv_d    = 1'b0;
    done_d  = 1'b0;
    mask_d  = '0;
    sstep_d = sstep_q;
    for (int i = 0; i < NC; i++) begin
      coef_d[i] = coef_q[i];
      if ((st_q == ST_IDLE) && load_valid && (int'(load_idx) == i))
        coef_d[i] = load_coef;
    end
    if (accept_start) begin
      st_d   = ST_RUN;
      emax_d = emax_c;
      thr_d  = thresh;
      acc_d  = NW'(emax_c) << 1;
      step_d = '0;
    end
    if (step_en) begin
      sv_d    = 1'b1;
      mask_d  = fire;
      sstep_d = step_q;
      acc_d   = acc_q + (NW'(emax_q) << 1);
      step_d  = step_q + 1'b1;
      if (step_q == SW'(T)) begin
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      emax_q  <= '0;
      thr_q   <= '0;
      acc_q   <= '0;
      step_q  <= '0;
      sv_q    <= 1'b0;
      done_q  <= 1'b0;
      mask_q  <= '0;
      sstep_q <= '0;
      for (int i = 0; i < NC; i++) coef_q[i] <= '0;
    end else begin
      st_q    <= st_d;
      emax_q  <= emax_d;
      thr_q   <= thr_d;
      acc_q   <= acc_d;
      step_q  <= step_d;
      sv_q    <= sv_d;
      done_q  <= done_d;
      mask_q  <= mask_d;
      sstep_q <= sstep_d;
      for (int i = 0; i < NC; i++) coef_q[i] <= coef_d[i];
    end
  end

  assign busy        = (st_q == ST_RUN);
  assign spike_valid = sv_q;
  assign spike_mask  = mask_q;
  assign spike_step  = sstep_q;
  assign done        = done_q;
endmodule

// File: rtl/dre_checker.sv
module dre_checker #(
  parameter int NC = 4,
  parameter int T  = 60,
  parameter int SW = $clog2(T + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic            busy,
  input logic            spike_valid,
  input logic [2*NC-1:0] spike_mask,
  input logic [SW-1:0]   spike_step,
  input logic            done
);
  logic [2*NC-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           seen_q <= '0;
    else if (!busy)       seen_q <= '0;
    else if (spike_valid) seen_q <= seen_q | spike_mask;
  end

  p_pulse_from_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    spike_valid |-> ($past(tick) && $past(busy)));

  p_done_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (spike_valid && (spike_step == SW'(T))));

  p_busy_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_quiet_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !spike_valid |-> (spike_mask == '0));

  p_one_rail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    spike_valid |-> ((spike_mask[NC-1:0] & spike_mask[2*NC-1:NC]) == '0));

  p_single_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spike_valid |-> ((spike_mask & seen_q) == '0));
endmodule

bind dual_rail_latency_encoder dre_checker #(.NC(NC), .T(T)) u_dre_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .busy        (busy),
  .spike_valid (spike_valid),
  .spike_mask  (spike_mask),
  .spike_step  (spike_step),
  .done        (done)
);

// File: tb/tb_dual_rail_latency_encoder.sv
module tb_dual_rail_latency_encoder;
  localparam int NC = 4;
  localparam int CW = 8;
  localparam int FW = 8;
  localparam int T  = 60;
  localparam int IW = 2;
  localparam int SW = 6;
  localparam int NV = 6;

  // {thresh, c3, c2, c1, c0}
  localparam logic [39:0] VECS [NV] = '{
    40'h1A_05_19_CE_64,
    40'h00_FF_00_7F_80,
    40'h1A_00_00_00_00,
    40'h64_01_03_FD_03,
    40'h28_40_C0_00_07,
    40'h00_FC_FD_FE_FF
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_valid = 1'b0;
  logic [IW-1:0] load_idx = '0;
  logic signed [CW-1:0] load_coef = '0;
  logic [FW-1:0] thresh = '0;
  logic start = 1'b0;
  logic tick = 1'b0;
  logic busy, spike_valid, done;
  logic [2*NC-1:0] spike_mask;
  logic [SW-1:0] spike_step;

  int checks = 0;
  int fails = 0;
  int cur [NC];
  int cur_thr = 0;

  always #5 clk = ~clk;

  dual_rail_latency_encoder #(.NC(NC), .CW(CW), .FW(FW), .T(T)) dut (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_idx(load_idx),
    .load_coef(load_coef), .thresh(thresh), .start(start), .tick(tick),
    .busy(busy), .spike_valid(spike_valid), .spike_mask(spike_mask),
    .spike_step(spike_step), .done(done)
  );

  function automatic logic [2*NC-1:0] exp_mask(input int step);
    int emax = 0;
    logic [2*NC-1:0] m = '0;
    for (int i = 0; i < NC; i++) begin
      int a = (cur[i] < 0) ? -cur[i] : cur[i];
      if (a > emax) emax = a;
    end
    for (int i = 0; i < NC; i++) begin
      int a = (cur[i] < 0) ? -cur[i] : cur[i];
      if (a != 0 && !(a * (1 << FW) < cur_thr * emax)) begin
        int t = (2 * T * (emax - a) + emax) / (2 * emax);
        if (t == step) m[(cur[i] < 0) ? i + NC : i] = 1'b1;
      end
    end
    return m;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_load(input int idx, input int val);
    @(negedge clk);
    load_valid = 1'b1; load_idx = IW'(idx); load_coef = CW'(val);
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  task automatic do_start(input int thr);
    @(negedge clk);
    start = 1'b1; thresh = FW'(thr);
    @(negedge clk);
    start = 1'b0;
    cur_thr = thr;
  endtask

  task automatic do_step(input int s);
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    // R2 step pulse, R3 R4 R5 R6 R7 R8 mask content
    check("R2 valid", 32'(spike_valid), 32'd1);
    check("R2 step", 32'(spike_step), 32'(s));
    check("R3 R4 R5 R6 R7 R8 mask", 32'(spike_mask), 32'(exp_mask(s)));
    check("R2 done", 32'(done), 32'(s == T));
    check("R2 busy", 32'(busy), 32'(s != T));
  endtask

  task automatic run_window(input int thr);
    do_start(thr);
    for (int s = 0; s <= T; s++) do_step(s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 busy", 32'(busy), 32'd0);
    check("R10 valid", 32'(spike_valid), 32'd0);
    check("R10 done", 32'(done), 32'd0);
    for (int i = 0; i < NC; i++) cur[i] = 0;
    // R10 coefficients zero after reset, R7 empty window
    run_window(26);

    // R2 tick while idle does nothing
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    check("R2 idle tick", 32'(spike_valid), 32'd0);

    // table walk: R1 loads, R3..R8 timing
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < NC; i++) begin
        cur[i] = $signed(VECS[v][i*8 +: 8]);
        do_load(i, cur[i]);
      end
      run_window(int'(VECS[v][39:32]));
    end

    // reuse vector 0 for directed cases
    for (int i = 0; i < NC; i++) begin
      cur[i] = $signed(VECS[0][i*8 +: 8]);
      do_load(i, cur[i]);
    end
    do_start(26);
    for (int s = 0; s < 10; s++) do_step(s);
    // R1 load while busy, R9 start while busy
    do_load(0, -5);
    do_load(2, 90);
    @(negedge clk); start = 1'b1; thresh = 8'd0;
    @(negedge clk); start = 1'b0;
    for (int s = 10; s < T; s++) do_step(s);
    // R9 final tick with a load in the same cycle
    @(negedge clk);
    tick = 1'b1; load_valid = 1'b1; load_idx = 2'd1; load_coef = 8'sd1;
    @(negedge clk);
    tick = 1'b0; load_valid = 1'b0;
    check("R9 done on final tick", 32'(done), 32'd1);
    check("R9 idle after window", 32'(busy), 32'd0);
    // R1 R9: stored coefficients unchanged
    run_window(26);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule